// File: doc/BRIEF.md
# Programmable Parse-Graph Header Parser

This block takes the header of an incoming packet as a byte stream and splits it into protocol headers by following a parse graph held in writable registers, not in fixed logic. Every graph node gives a header length, the place of the field that selects the next header, up to four selector values with their successor nodes, an optional fallback successor, a terminal flag, and the byte position in the output vector where the header's bytes are stored. Node 0 is always where parsing starts.

A walker state machine copies each header byte into a fixed-width header vector. It marks each parsed header type in a valid mask. At the end of the parse it raises done, and raises error as well when the parse failed. Downstream match-action stages read the vector and the mask. A new protocol can be placed between two existing ones by rewriting graph registers alone. The register-write port is open only while no packet is in flight.

Top module: `pg_hdr_parser`

## Requirements
- R1: After reset the graph holds five nodes. Node 0 is Ethernet: 14 bytes, two-byte selector at offset 12, 0x0800 leads to node 1 and 0x86DD leads to node 2, vector base 0. Node 1 is IPv4: 20 bytes, one-byte selector at offset 9, base 14. Node 2 is IPv6: 40 bytes, one-byte selector at offset 6, base 34. In both nodes 1 and 2, value 6 leads to node 3 and value 17 leads to node 4. Node 3 is TCP: terminal, 20 bytes, base 74. Node 4 is UDP: terminal, 8 bytes, base 94. Nodes 5 to 7 are all zero: they have no arcs, no fallback and are not terminal.
- R2: Byte i of a header at node n is stored in vector byte (base of n)+i, which sits on `hvec` bits [8k+7:8k] for k = that byte index. Writes at or above HV_BYTES are dropped. Every byte not written since the packet's first byte reads zero.
- R3: The selector is the byte at the node's selector offset. When the two-byte flag is set, it is that byte followed by the next one, big-endian. When several enabled arcs match the selector, the arc with the lowest index wins. With no match, the fallback successor is used if it is enabled.
- R4: When a non-terminal header ends, no enabled arc matches and no fallback is enabled, done and err are both set.
- R5: When a terminal header ends, done is set and err is not. Bytes that follow, up to the end marker, change neither the vector nor the mask.
- R6: Parsing stops without error once MAX_HDRS headers have been parsed, even if the last one is not terminal.
- R7: An end marker on a byte after which parsing is not finished sets done and err.
- R8: A write with `cfg_we` high updates node `cfg_addr[5:3]`, word `cfg_addr[2:0]`, but only while `busy` is low. Word 0 layout: [5:0] length, [11:6] selector offset, [12] two-byte selector, [13] terminal, [14] fallback enable, [17:15] fallback node, [25:18] vector base. Words 1 to 4 each hold arc 0 to 3: [15:0] value, [18:16] successor node, [19] enable. A write while `busy` is high is ignored.
- R9: Bit n of `hdr_valid` is set once a header at node n has been fully parsed. The whole mask clears on the first byte of a packet.
- R10: `done` and `err` hold their value until the next start byte. Bytes with valid high but no start marker while idle are ignored. `busy` is high from the start byte until the byte carrying the end marker.
- R11: A start byte during a packet abandons that packet and begins a new parse with that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte on in_data is valid |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| in_data | input | 8 | Stream byte |
| cfg_we | input | 1 | Graph register write strobe |
| cfg_addr | input | 6 | Node index [5:3], word index [2:0] |
| cfg_wdata | input | 32 | Graph register write data |
| hvec | output | HV_BYTES*8 | Header vector, byte k on bits [8k+7:8k] |
| hdr_valid | output | N_NODES | Parsed-header mask, one bit per node |
| done | output | 1 | Parse finished |
| err | output | 1 | Parse finished in error |
| busy | output | 1 | Packet in flight; graph writes blocked |

## Verification
The bench builds the parser with N_NODES=8, MAX_HDRS=4 and HV_BYTES=64. With a 64-byte vector, the default layout of the IPv6 tail and of both transport headers spills past the end, so the dropping of out-of-range writes is exercised on every ordinary packet. With a limit of four, a reprogrammed self-looping node reaches the header cap after a few bytes, and a four-deep chain with an inserted shim header ends exactly at the cap. Random packets mix the known and unknown selector values, truncations and idle gaps, and are compared against a bench model that walks a shadow copy of the graph.

// File: rtl/pgp_pkg.sv
package pgp_pkg;

  localparam int NODE_W  = 3;
  localparam int N_ARCS  = 4;
  localparam int LEN_W   = 6;
  localparam int VB_W    = 8;
  localparam int LANE_W  = 9;

  typedef struct packed {
    logic              en;
    logic [NODE_W-1:0] nxt;
    logic [15:0]       val;
  } arc_t;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [LEN_W-1:0]  sel_off;
    logic              sel_two;
    logic              term;
    logic              fb_en;
    logic [NODE_W-1:0] fb_nxt;
    logic [VB_W-1:0]   vbase;
    arc_t [N_ARCS-1:0] arcs;
  } gnode_t;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DRAIN} wstate_e;

  function automatic arc_t mk_arc(input logic [15:0] v, input logic [NODE_W-1:0] n);
    arc_t a;
    a.en  = 1'b1;
    a.nxt = n;
    a.val = v;
    return a;
  endfunction

  function automatic gnode_t mk_node(input logic [LEN_W-1:0] len, input logic [LEN_W-1:0] off,
                                     input logic two, input logic term, input logic [VB_W-1:0] vb);
    gnode_t g;
    g         = '0;
    g.len     = len;
    g.sel_off = off;
    g.sel_two = two;
    g.term    = term;
    g.vbase   = vb;
    return g;
  endfunction

  // Power-up graph: L2 -> L3 (v4/v6) -> L4 (stream/datagram).
  function automatic gnode_t boot_node(input int idx);
    gnode_t g;
    g = '0;
    case (idx)
      0: begin
        g = mk_node(6'd14, 6'd12, 1'b1, 1'b0, 8'd0);
        g.arcs[0] = mk_arc(16'h0800, 3'd1);
        g.arcs[1] = mk_arc(16'h86DD, 3'd2);
      end
      1: begin
        g = mk_node(6'd20, 6'd9, 1'b0, 1'b0, 8'd14);
        g.arcs[0] = mk_arc(16'd6, 3'd3);
        g.arcs[1] = mk_arc(16'd17, 3'd4);
      end
      2: begin
        g = mk_node(6'd40, 6'd6, 1'b0, 1'b0, 8'd34);
        g.arcs[0] = mk_arc(16'd6, 3'd3);
        g.arcs[1] = mk_arc(16'd17, 3'd4);
      end
      3: g = mk_node(6'd20, 6'd0, 1'b0, 1'b1, 8'd74);
      4: g = mk_node(6'd8, 6'd0, 1'b0, 1'b1, 8'd94);
      default: g = '0;
    endcase
    return g;
  endfunction

  // Merge one 32-bit configuration word into a node.
  function automatic gnode_t put_word(input gnode_t cur, input logic [2:0] w, input logic [31:0] d);
    gnode_t g;
    g = cur;
    case (w)
      3'd0: begin
        g.len     = d[5:0];
        g.sel_off = d[11:6];
        g.sel_two = d[12];
        g.term    = d[13];
        g.fb_en   = d[14];
        g.fb_nxt  = d[17:15];
        g.vbase   = d[25:18];
      end
      3'd1, 3'd2, 3'd3, 3'd4: begin
        g.arcs[w - 3'd1].val = d[15:0];
        g.arcs[w - 3'd1].nxt = d[18:16];
        g.arcs[w - 3'd1].en  = d[19];
      end
      default: g = cur;
    endcase
    return g;
  endfunction

  // Selector accumulation for one incoming byte.
  function automatic logic [15:0] sel_step(input logic [15:0] acc, input logic [7:0] b,
                                           input logic [LEN_W-1:0] idx, input logic [LEN_W-1:0] off,
                                           input logic two);
    if (idx == off) return {8'h00, b};
    if (two && (idx == off + 6'd1)) return {acc[7:0], b};
    return acc;
  endfunction

  function automatic logic [LANE_W-1:0] lane_of(input logic [VB_W-1:0] vb, input logic [LEN_W-1:0] idx);
    return {1'b0, vb} + {3'b000, idx};
  endfunction

endpackage

// File: rtl/pgp_graph.sv
module pgp_graph
  import pgp_pkg::*;
#(
  parameter int N_NODES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              cfg_we,
  input  logic [5:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [NODE_W-1:0] rd_node,
  output gnode_t            rd_entry
);

  gnode_t [N_NODES-1:0] tbl;
  logic                 wr_take;
  logic                 wr_blocked;

  assign wr_take    = cfg_we && idle && ({29'd0, cfg_addr[5:3]} < N_NODES);
  assign wr_blocked = cfg_we && !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_NODES; i++) tbl[i] <= boot_node(i);
    end else if (wr_take) begin
      for (int i = 0; i < N_NODES; i++)
        if (cfg_addr[5:3] == NODE_W'(i)) tbl[i] <= put_word(tbl[i], cfg_addr[2:0], cfg_wdata);
    end
  end

  always_comb begin
    rd_entry = '0;
    for (int i = 0; i < N_NODES; i++)
      if (rd_node == NODE_W'(i)) rd_entry = tbl[i];
  end

  AST_BUSY_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> $stable(tbl)); // R8

endmodule

// File: rtl/pgp_next_sel.sv
module pgp_next_sel
  import pgp_pkg::*;
#(
  parameter int N_NODES = 8
) (
  input  gnode_t            ent,
  input  logic [15:0]       sel,
  output logic              found,
  output logic [NODE_W-1:0] nxt
);

  logic [N_ARCS-1:0] hit;

  generate
    for (genvar a = 0; a < N_ARCS; a++) begin : g_arc
      assign hit[a] = ent.arcs[a].en && (ent.arcs[a].val == sel)
                      && ({29'd0, ent.arcs[a].nxt} < N_NODES);
    end
  endgenerate

  always_comb begin
    found = 1'b0;
    nxt   = '0;
    if (ent.fb_en && ({29'd0, ent.fb_nxt} < N_NODES)) begin
      found = 1'b1;
      nxt   = ent.fb_nxt;
    end
    for (int a = N_ARCS - 1; a >= 0; a--) begin
      if (hit[a]) begin
        found = 1'b1;
        nxt   = ent.arcs[a].nxt;
      end
    end
  end

endmodule

// File: rtl/pgp_hvec.sv
module pgp_hvec
  import pgp_pkg::*;
#(
  parameter int HV_BYTES = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [LANE_W-1:0]     wr_addr,
  input  logic [7:0]            wr_byte,
  output logic [HV_BYTES*8-1:0] hvec
);

  logic [7:0] lanes [HV_BYTES];

  generate
    for (genvar k = 0; k < HV_BYTES; k++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     lanes[k] <= 8'h00;
        else if (wr_en && (wr_addr == LANE_W'(k)))      lanes[k] <= wr_byte;
        else if (clr)                                   lanes[k] <= 8'h00;
      end
      assign hvec[8*k +: 8] = lanes[k];
    end
  endgenerate

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> $stable(hvec)); // R2

endmodule

// File: rtl/pgp_walker.sv
module pgp_walker
  import pgp_pkg::*;
#(
  parameter int N_NODES  = 8,
  parameter int MAX_HDRS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic [7:0]         in_data,
  input  gnode_t             ent,
  input  logic               found,
  input  logic [NODE_W-1:0]  nxt,
  output logic [NODE_W-1:0]  rd_node,
  output logic [15:0]        sel_now,
  output logic               lane_wr,
  output logic [LANE_W-1:0]  lane_addr,
  output logic               clr,
  output logic [N_NODES-1:0] hdr_valid,
  output logic               done,
  output logic               err,
  output logic               busy,
  output logic               idle
);

  localparam int CNT_W = $clog2(MAX_HDRS + 1);

  wstate_e            st;
  logic [NODE_W-1:0]  cur, cur_eff;
  logic [LEN_W-1:0]   bidx, idx_eff;
  logic [15:0]        sel_acc, sel_eff;
  logic [CNT_W-1:0]   hcnt, cnt_eff, cnt_nxt;
  logic [N_NODES-1:0] hv_q, hv_nxt;
  logic               done_q, err_q;

  // Named internal events.
  logic start, act, hdr_end, adv, fin_ok, fin_bad, parse_end;

  assign start   = in_valid && in_sop;
  assign act     = in_valid && (start || (st == ST_HDR));
  assign cur_eff = start ? '0 : cur;
  assign idx_eff = start ? '0 : bidx;
  assign sel_eff = start ? '0 : sel_acc;
  assign cnt_eff = start ? '0 : hcnt;
  assign rd_node = cur_eff;

  assign sel_now   = sel_step(sel_eff, in_data, idx_eff, ent.sel_off, ent.sel_two);
  assign hdr_end   = act && (idx_eff == ent.len - 6'd1);
  assign cnt_nxt   = cnt_eff + CNT_W'(1);
  assign fin_ok    = hdr_end && (ent.term || (found && (cnt_nxt == CNT_W'(MAX_HDRS))));
  assign adv       = hdr_end && !ent.term && found && (cnt_nxt != CNT_W'(MAX_HDRS));
  assign fin_bad   = act && !fin_ok && (in_eop || (hdr_end && !ent.term && !found));
  assign parse_end = fin_ok || fin_bad;

  assign lane_wr   = act;
  assign lane_addr = lane_of(ent.vbase, idx_eff);
  assign clr       = start;

  assign hv_nxt = (start ? '0 : hv_q) | (hdr_end ? (N_NODES'(1) << cur_eff) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cur     <= '0;
      bidx    <= '0;
      sel_acc <= '0;
      hcnt    <= '0;
      hv_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      hv_q <= hv_nxt;
      if (act) begin
        if (parse_end) begin
          st     <= in_eop ? ST_IDLE : ST_DRAIN;
          done_q <= 1'b1;
          err_q  <= fin_bad;
        end else begin
          st <= ST_HDR;
          if (start) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
          end
        end
        if (adv) begin
          cur     <= nxt;
          bidx    <= '0;
          sel_acc <= '0;
          hcnt    <= cnt_nxt;
        end else begin
          cur     <= cur_eff;
          bidx    <= idx_eff + 6'd1;
          sel_acc <= sel_now;
          hcnt    <= hdr_end ? cnt_nxt : cnt_eff;
        end
      end else if ((st == ST_DRAIN) && in_valid && in_eop) begin
        st <= ST_IDLE;
      end
    end
  end

  assign hdr_valid = hv_q;
  assign done      = done_q;
  assign err       = err_q;
  assign idle      = (st == ST_IDLE);
  assign busy      = !idle;

  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R4
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10
  AST_HDR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= CNT_W'(MAX_HDRS)); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !hdr_end) |=> (hdr_valid == '0)); // R9
  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(hdr_valid)); // R5
  AST_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !parse_end) |=> (busy && !done)); // R11

endmodule

// File: rtl/pg_hdr_parser.sv
module pg_hdr_parser
  import pgp_pkg::*;
#(
  parameter int N_NODES  = 8,
  parameter int MAX_HDRS = 8,
  parameter int HV_BYTES = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_sop,
  input  logic                  in_eop,
  input  logic [7:0]            in_data,
  input  logic                  cfg_we,
  input  logic [5:0]            cfg_addr,
  input  logic [31:0]           cfg_wdata,
  output logic [HV_BYTES*8-1:0] hvec,
  output logic [N_NODES-1:0]    hdr_valid,
  output logic                  done,
  output logic                  err,
  output logic                  busy
);

  gnode_t            ent;
  logic [NODE_W-1:0] rd_node, nxt;
  logic [15:0]       sel_now;
  logic              found, lane_wr, clr, idle;
  logic [LANE_W-1:0] lane_addr;

  pgp_graph #(.N_NODES(N_NODES)) u_graph (
    .clk(clk), .rst_n(rst_n), .idle(idle), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_node(rd_node), .rd_entry(ent)
  );

  pgp_next_sel #(.N_NODES(N_NODES)) u_sel (
    .ent(ent), .sel(sel_now), .found(found), .nxt(nxt)
  );

  pgp_walker #(.N_NODES(N_NODES), .MAX_HDRS(MAX_HDRS)) u_walk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .ent(ent), .found(found), .nxt(nxt), .rd_node(rd_node),
    .sel_now(sel_now), .lane_wr(lane_wr), .lane_addr(lane_addr), .clr(clr),
    .hdr_valid(hdr_valid), .done(done), .err(err), .busy(busy), .idle(idle)
  );

  pgp_hvec #(.HV_BYTES(HV_BYTES)) u_vec (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(lane_wr), .wr_addr(lane_addr),
    .wr_byte(in_data), .hvec(hvec)
  );

endmodule

// File: tb/pg_hdr_parser_tb.sv
module pg_hdr_parser_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NN  = 8;
  localparam int MXH = 4;
  localparam int HVB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [HVB*8-1:0] hvec;
  logic [NN-1:0] hdr_valid;
  logic done, err, busy;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pg_hdr_parser #(.N_NODES(NN), .MAX_HDRS(MXH), .HV_BYTES(HVB)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hvec(hvec), .hdr_valid(hdr_valid), .done(done), .err(err), .busy(busy)
  );

  // Shadow graph (R1 / R8 encodings).
  int m_len[NN], m_off[NN], m_two[NN], m_term[NN], m_fe[NN], m_fn[NN], m_base[NN];
  int m_av[NN][4], m_an[NN][4], m_ae[NN][4];

  logic [7:0] pkt [0:127];
  int pn;
  logic [7:0] exp_vec [HVB];
  logic [NN-1:0] exp_valid;
  logic exp_err;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void shadow_boot();
    for (int n = 0; n < NN; n++) begin
      m_len[n] = 0; m_off[n] = 0; m_two[n] = 0; m_term[n] = 0; m_fe[n] = 0; m_fn[n] = 0; m_base[n] = 0;
      for (int a = 0; a < 4; a++) begin m_av[n][a] = 0; m_an[n][a] = 0; m_ae[n][a] = 0; end
    end
    m_len[0] = 14; m_off[0] = 12; m_two[0] = 1;
    m_av[0][0] = 16'h0800; m_an[0][0] = 1; m_ae[0][0] = 1;
    m_av[0][1] = 16'h86DD; m_an[0][1] = 2; m_ae[0][1] = 1;
    m_len[1] = 20; m_off[1] = 9; m_base[1] = 14;
    m_len[2] = 40; m_off[2] = 6; m_base[2] = 34;
    for (int n = 1; n <= 2; n++) begin
      m_av[n][0] = 6;  m_an[n][0] = 3; m_ae[n][0] = 1;
      m_av[n][1] = 17; m_an[n][1] = 4; m_ae[n][1] = 1;
    end
    m_len[3] = 20; m_term[3] = 1; m_base[3] = 74;
    m_len[4] = 8;  m_term[4] = 1; m_base[4] = 94;
  endfunction

  task automatic cfg_wr(input int node, input int w, input logic [31:0] d, input bit track);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {node[2:0], w[2:0]}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (track) begin
      if (w == 0) begin
        m_len[node] = d[5:0]; m_off[node] = d[11:6]; m_two[node] = d[12]; m_term[node] = d[13];
        m_fe[node] = d[14]; m_fn[node] = d[17:15]; m_base[node] = d[25:18];
      end else if (w <= 4) begin
        m_av[node][w-1] = d[15:0]; m_an[node][w-1] = d[18:16]; m_ae[node][w-1] = d[19];
      end
    end
  endtask

  // Model of R2-R7, R9 over pkt[0..n-1].
  task automatic model(input int n);
    int cur, idx, sel, cnt, addr, nx;
    bit fin, fnd;
    cur = 0; idx = 0; sel = 0; cnt = 0; fin = 0;
    exp_err = 0; exp_valid = '0;
    for (int k = 0; k < HVB; k++) exp_vec[k] = 8'h00;
    for (int i = 0; i < n && !fin; i++) begin
      addr = m_base[cur] + idx;
      if (addr < HVB) exp_vec[addr] = pkt[i];
      if (idx == m_off[cur]) sel = pkt[i];
      else if (m_two[cur] != 0 && idx == ((m_off[cur] + 1) & 63)) sel = ((sel << 8) | pkt[i]) & 16'hFFFF;
      if (idx == ((m_len[cur] - 1) & 63)) begin
        exp_valid[cur] = 1'b1;
        cnt++;
        if (m_term[cur] != 0) fin = 1;
        else begin
          fnd = 0; nx = 0;
          for (int a = 0; a < 4; a++)
            if (!fnd && m_ae[cur][a] != 0 && m_av[cur][a] == sel) begin fnd = 1; nx = m_an[cur][a]; end
          if (!fnd && m_fe[cur] != 0) begin fnd = 1; nx = m_fn[cur]; end
          if (!fnd) begin fin = 1; exp_err = 1; end
          else if (cnt == MXH) fin = 1;
          else begin cur = nx; idx = 0; sel = 0; end
        end
      end else idx++;
      if (!fin && i == n - 1) begin fin = 1; exp_err = 1; end
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_sop = s; in_eop = e; in_data = b;
  endtask

  task automatic gap();
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic send(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) gap();
      put_byte(pkt[i], i == 0, i == n - 1);
    end
    gap();
    gap();
  endtask

  task automatic check_model(input string req, input int n);
    int bad_k;
    model(n);
    chk(req, "done", {63'd0, done}, 64'd1);
    chk(req, "err", {63'd0, err}, {63'd0, exp_err});
    chk(req, "hdr_valid", {56'd0, hdr_valid}, {56'd0, exp_valid});
    bad_k = -1;
    for (int k = 0; k < HVB; k++)
      if (bad_k < 0 && hvec[8*k +: 8] !== exp_vec[k]) bad_k = k;
    if (bad_k >= 0) chk(req, "hvec byte", {56'd0, hvec[8*bad_k +: 8]}, {56'd0, exp_vec[bad_k]});
    else chk(req, "hvec", 64'd0, 64'd0);
  endtask

  // Builds L2 + L3 + L4 + payload with chosen selector values.
  task automatic build(input logic [15:0] et, input logic [7:0] proto, input bit v6, input bit udp, input int pay);
    int l3, l4;
    l3 = v6 ? 40 : 20;
    l4 = udp ? 8 : 20;
    pn = 14 + l3 + l4 + pay;
    for (int i = 0; i < pn; i++) pkt[i] = 8'($urandom);
    pkt[12] = et[15:8];
    pkt[13] = et[7:0];
    pkt[14 + (v6 ? 6 : 9)] = proto;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    shadow_boot();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state (R10, R9)
    chk("R10", "busy at reset", {63'd0, busy}, 64'd0);
    chk("R10", "done at reset", {63'd0, done}, 64'd0);
    chk("R9", "mask at reset", {56'd0, hdr_valid}, 64'd0);

    // R1: default graph, v4 + stream transport
    build(16'h0800, 8'd6, 0, 0, 5);
    send(pn, 0);
    chk("R1", "mask v4/tcp", {56'd0, hdr_valid}, 64'h0B);
    chk("R2", "vec byte 14", {56'd0, hvec[8*14 +: 8]}, {56'd0, pkt[14]});
    check_model("R1", pn);

    // R1: v6 + datagram, tail spills past the vector (R2)
    build(16'h86DD, 8'd17, 1, 1, 0);
    send(pn, 1);
    chk("R1", "mask v6/udp", {56'd0, hdr_valid}, 64'h15);
    check_model("R2", pn);

    // R10: stray bytes in idle change nothing
    put_byte(8'hAA, 1'b0, 1'b0);
    put_byte(8'h55, 1'b0, 1'b1);
    gap();
    check_model("R10", pn);

    // R4: unknown ethertype
    build(16'h1234, 8'd6, 0, 0, 3);
    send(pn, 0);
    chk("R4", "err unknown", {63'd0, err}, 64'd1);
    check_model("R4", pn);

    // R7: truncated inside L3
    build(16'h0800, 8'd6, 0, 0, 0);
    pn = 20;
    send(pn, 1);
    chk("R7", "err trunc", {63'd0, err}, 64'd1);
    check_model("R7", pn);

    // R8: write during a packet is ignored
    build(16'h0800, 8'd17, 0, 1, 2);
    for (int i = 0; i < 6; i++) put_byte(pkt[i], i == 0, 1'b0);
    gap();
    cfg_wr(0, 0, 32'h0000_0004, 0);
    for (int i = 6; i < pn; i++) put_byte(pkt[i], 1'b0, i == pn - 1);
    gap(); gap();
    check_model("R8", pn);
    send(pn, 0);
    check_model("R8", pn);

    // R11: restart mid-packet
    build(16'h86DD, 8'd6, 1, 0, 0);
    for (int i = 0; i < 9; i++) put_byte(8'($urandom), i == 0, 1'b0);
    send(pn, 0);
    check_model("R11", pn);

    // R8: insert a shim header between L3 and L4 at idle
    cfg_wr(1, 3, (32'd1 << 19) | (32'd5 << 16) | 32'h00FE, 1);
    cfg_wr(5, 0, 32'd4 | (32'd1 << 6) | (32'd40 << 18), 1);
    cfg_wr(5, 1, (32'd1 << 19) | (32'd3 << 16) | 32'd6, 1);
    cfg_wr(5, 2, (32'd1 << 19) | (32'd4 << 16) | 32'd17, 1);
    pn = 14 + 20 + 4 + 8;
    for (int i = 0; i < pn; i++) pkt[i] = 8'($urandom);
    pkt[12] = 8'h08; pkt[13] = 8'h00; pkt[23] = 8'hFE; pkt[35] = 8'd17;
    send(pn, 0);
    chk("R8", "mask shim", {56'd0, hdr_valid}, 64'h33);
    chk("R8", "shim byte", {56'd0, hvec[8*41 +: 8]}, 64'd17);
    check_model("R8", pn);

    // R6: self-looping node hits the header cap
    cfg_wr(0, 3, (32'd1 << 19) | (32'd6 << 16) | 32'h88B5, 1);
    cfg_wr(6, 0, 32'd2 | (32'd1 << 14) | (32'd6 << 15) | (32'd50 << 18), 1);
    pn = 30;
    for (int i = 0; i < pn; i++) pkt[i] = 8'($urandom);
    pkt[12] = 8'h88; pkt[13] = 8'hB5;
    send(pn, 0);
    chk("R6", "err at cap", {63'd0, err}, 64'd0);
    chk("R6", "mask at cap", {56'd0, hdr_valid}, 64'h41);
    chk("R5", "tail ignored", {56'd0, hvec[8*50 +: 8]}, {56'd0, pkt[18]});
    check_model("R6", pn);

    // R3: two matching arcs, lowest index wins
    cfg_wr(7, 0, 32'd3 | (32'd1 << 13) | (32'd60 << 18), 1);
    cfg_wr(6, 1, (32'd1 << 19) | (32'd7 << 16) | 32'd5, 1);
    cfg_wr(6, 2, (32'd1 << 19) | (32'd3 << 16) | 32'd5, 1);
    pn = 22;
    for (int i = 0; i < pn; i++) pkt[i] = 8'($urandom);
    pkt[12] = 8'h88; pkt[13] = 8'hB5; pkt[14] = 8'd5;
    send(pn, 0);
    chk("R3", "mask priority", {56'd0, hdr_valid}, 64'hC1);
    check_model("R3", pn);

    // Random mix (R2 R3 R4 R5 R6 R7 R9)
    for (int t = 0; t < 160; t++) begin
      logic [15:0] et;
      logic [7:0] pr;
      case ($urandom % 5)
        0: et = 16'h0800; 1: et = 16'h86DD; 2: et = 16'h88B5; 3: et = 16'h0800;
        default: et = 16'($urandom);
      endcase
      case ($urandom % 4)
        0: pr = 8'd6; 1: pr = 8'd17; 2: pr = 8'hFE; default: pr = 8'($urandom);
      endcase
      build(et, pr, et == 16'h86DD, $urandom % 2 == 1, $urandom % 8);
      if (pr == 8'hFE) pkt[35] = ($urandom % 2 == 1) ? 8'd6 : 8'($urandom % 20);
      if (et == 16'h88B5) pkt[14] = 8'($urandom % 8);
      if ($urandom % 5 == 0) pn = 1 + ($urandom % pn);
      send(pn, 1);
      check_model("R9", pn);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule